// File: doc/BRIEF.md
# Video Decoder Interrupt Controller

This block gathers events from a line-21 caption and extended-data decoder and turns them into one interrupt line for a host processor. It watches the lock indication and four activity levels (selected channel, extended data, caption, text). Any change of level on one of these inputs is latched into a sticky request bit. The host clears a latched bit by writing a one to it. Two status levels, end-of-field and data-line-ended, are shown live in the same request word. The host cannot clear them; the video timing upstream drops them once in every field.

A mask register enables each request bit as an interrupt source. Its lowest bit has no request bit to pair with. Instead it enables a data-available level straight onto the interrupt line. The host reads and writes both registers over a simple byte-wide bus with one address and one write strobe. Read data is combinational from the address.

Top module: `vid_irq_ctrl`

## Requirements
- R1: After reset, every request and mask bit is 0 and `irqOut` is low.
- R2: Reading address 0x06 returns the request word, reading 0x07 returns the mask, and any other address reads 0x00.
- R3: Request bit 3 sets in the cycle after `lockIn` changes, for a rise and for a fall alike.
- R4: Request bits 4, 5, 6 and 7 set in the cycle after `schActive`, `xdsActive`, `capActive` and `txtActive` change level, in that order.
- R5: A set change bit stays set when its input returns to its earlier level, and stays set until the host clears it.
- R6: A write to 0x06 clears each of bits 7..3 whose write-data bit is 1. Bits written with 0 keep their value.
- R7: Request bit 2 shows `eofIn` and bit 1 shows `dleIn` as live levels, and writes to 0x06 do not change them. Request bit 0 always reads 0.
- R8: A write to 0x07 loads all eight mask bits, and the mask reads back exactly as written.
- R9: `irqOut` is high exactly when some request bit 7..1 and its mask bit are both 1, or when `davIn` and mask bit 0 are both 1. An all-zero mask keeps `irqOut` low.
- R10: If a change event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R11: Levels present on the inputs when reset is released do not count as changes. The first sample taken after reset only primes the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lockIn | input | 1 | Decoder lock level |
| schActive | input | 1 | Selected-channel activity level |
| xdsActive | input | 1 | Extended-data activity level |
| capActive | input | 1 | Caption activity level |
| txtActive | input | 1 | Text activity level |
| eofIn | input | 1 | End-of-field status level |
| dleIn | input | 1 | Data-line-ended status level |
| davIn | input | 1 | Data-available level |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 8 | Register address |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data |
| irqOut | output | 1 | Interrupt to host, active high |

## Verification
Each activity and lock input is driven with a rise, a fall, and a short pulse that returns to its earlier level. Together these show edge detection in both directions and the stickiness of a bit after its input returns. Clearing writes are tried with all-zero data, a single bit, and all ones. These separate the bits that can be cleared from the status bits, which stay live. A write that lands in the same cycle as a change shows which of the two wins. Levels held through reset show that reset is not taken as a change. A long run of random inputs, random writes and random masks with `davIn` exercises the interrupt equation across all mask and request combinations.

// File: rtl/vdic_pkg.sv
package vdic_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int NUM_CHG   = 5;
  localparam int CHG_LSB   = 3;
  localparam logic [ADDR_W-1:0] REQ_ADDR  = 8'h06;
  localparam logic [ADDR_W-1:0] MASK_ADDR = 8'h07;

  typedef struct packed {
    logic [NUM_CHG-1:0] clrChg;
    logic               maskLoad;
    logic               selReq;
    logic               selMask;
  } ctrlStrb_t;
endpackage

// File: rtl/vdic_ctrl.sv
module vdic_ctrl
  import vdic_pkg::*;
(
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output ctrlStrb_t         strb
);
  logic hitReq;
  logic hitMask;

  always_comb begin
    hitReq         = (busAddr == REQ_ADDR);
    hitMask        = (busAddr == MASK_ADDR);
    strb.selReq    = hitReq;
    strb.selMask   = hitMask;
    strb.maskLoad  = busWe && hitMask;
    strb.clrChg    = (busWe && hitReq) ? busWdata[CHG_LSB +: NUM_CHG] : '0;
  end
endmodule

// File: rtl/vdic_dp.sv
module vdic_dp
  import vdic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CHG-1:0] evtIn,
  input  logic               eofIn,
  input  logic               dleIn,
  input  logic               davIn,
  input  logic [DATA_W-1:0]  busWdata,
  input  ctrlStrb_t          strb,
  output logic [DATA_W-1:0]  reqBits,
  output logic [DATA_W-1:0]  maskBits,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut
);
  logic [NUM_CHG-1:0] prevEvt;
  logic [NUM_CHG-1:0] chgSticky;
  logic               primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevEvt <= '0;
      primed  <= 1'b0;
    end else begin
      prevEvt <= evtIn;
      primed  <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CHG; i++) begin : g_chg
    logic evtEdge;
    assign evtEdge = primed && (evtIn[i] != prevEvt[i]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chgSticky[i] <= 1'b0;
      else       chgSticky[i] <= evtEdge || (chgSticky[i] && !strb.clrChg[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskBits <= '0;
    else if (strb.maskLoad) maskBits <= busWdata;
  end

  assign reqBits = {chgSticky, eofIn, dleIn, 1'b0};

  always_comb begin
    if (strb.selReq)       busRdata = reqBits;
    else if (strb.selMask) busRdata = maskBits;
    else                   busRdata = '0;
  end

  assign irqOut = (|(reqBits[DATA_W-1:1] & maskBits[DATA_W-1:1])) ||
                  (davIn && maskBits[0]);
endmodule

// File: rtl/vid_irq_ctrl.sv
module vid_irq_ctrl
  import vdic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lockIn,
  input  logic              schActive,
  input  logic              xdsActive,
  input  logic              capActive,
  input  logic              txtActive,
  input  logic              eofIn,
  input  logic              dleIn,
  input  logic              davIn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  ctrlStrb_t          strb;
  logic [NUM_CHG-1:0] evtIn;
  logic [DATA_W-1:0]  reqBits;
  logic [DATA_W-1:0]  maskBits;

  assign evtIn = {txtActive, capActive, xdsActive, schActive, lockIn};

  vdic_ctrl u_ctrl (
    .busWe   (busWe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .strb    (strb)
  );

  vdic_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .eofIn   (eofIn),
    .dleIn   (dleIn),
    .davIn   (davIn),
    .busWdata(busWdata),
    .strb    (strb),
    .reqBits (reqBits),
    .maskBits(maskBits),
    .busRdata(busRdata),
    .irqOut  (irqOut)
  );
endmodule

// File: rtl/vdic_chk.sv
module vdic_chk
  import vdic_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              lockIn,
  input logic              txtActive,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] reqBits,
  input logic [DATA_W-1:0] maskBits,
  input logic              irqOut
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (reqBits[7:3] == 5'd0) && (maskBits == 8'd0));

  // R3
  lock_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (lockIn != $past(lockIn))) |=> reqBits[3]);

  // R4
  txt_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (txtActive != $past(txtActive))) |=> reqBits[7]);

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqBits[3] && !(busWe && busAddr == REQ_ADDR && busWdata[3])) |=> reqBits[3]);

  // R9
  mask_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskBits == 8'd0) |-> !irqOut);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && busWe && busAddr == REQ_ADDR && busWdata[7] &&
     (txtActive != $past(txtActive))) |=> reqBits[7]);
endmodule

bind vid_irq_ctrl vdic_chk u_vdic_chk (
  .clk      (clk),
  .rstN     (rstN),
  .lockIn   (lockIn),
  .txtActive(txtActive),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .reqBits  (reqBits),
  .maskBits (maskBits),
  .irqOut   (irqOut)
);

// File: tb/test_vid_irq_ctrl.sv
module test_vid_irq_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lockIn = 0, schActive = 0, xdsActive = 0, capActive = 0, txtActive = 0;
  logic       eofIn = 0, dleIn = 0, davIn = 0;
  logic       busWe = 0;
  logic [7:0] busAddr = 8'h06;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       irqOut;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string phase = "R1";

  bit [7:0] mReq = 0;
  bit [7:0] mMask = 0;
  bit [4:0] mPrev = 0;
  bit       mPrimed = 0;

  always #2 clk = ~clk;

  vid_irq_ctrl i_vid_irq_ctrl (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .schActive(schActive),
    .xdsActive(xdsActive), .capActive(capActive), .txtActive(txtActive),
    .eofIn(eofIn), .dleIn(dleIn), .davIn(davIn), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  // reference model: change bits at positions 7..3, sampled per clock
  always @(posedge clk) begin
    bit [4:0] cur;
    cur = {txtActive, capActive, xdsActive, schActive, lockIn};
    if (!rstN) begin
      mReq = 0; mMask = 0; mPrev = 0; mPrimed = 0;
    end else begin
      for (int i = 0; i < 5; i++) begin
        bit evt;
        bit clr;
        evt = mPrimed && (cur[i] != mPrev[i]);
        clr = busWe && (busAddr == 8'h06) && busWdata[i+3];
        mReq[i+3] = evt || (mReq[i+3] && !clr);
      end
      if (busWe && busAddr == 8'h07) mMask = busWdata;
      mPrev = cur;
      mPrimed = 1;
    end
  end

  function automatic bit [7:0] expWord();
    bit [7:0] w;
    w = {mReq[7:3], eofIn, dleIn, 1'b0};
    if (busAddr == 8'h06) return w;
    if (busAddr == 8'h07) return mMask;
    return 8'h00;
  endfunction

  function automatic bit expIrq();
    bit [7:0] w;
    w = {mReq[7:3], eofIn, dleIn, 1'b0};
    return (|(w[7:1] & mMask[7:1])) || (davIn && mMask[0]);
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(phase, "rdata", busRdata, expWord());
      chk(phase, "irq", {7'd0, irqOut}, {7'd0, expIrq()});
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    busWe = 1; busAddr = a; busWdata = d;
    step();
    busWe = 0; busAddr = 8'h06; busWdata = 8'h00;
  endtask

  initial begin
    // R11: levels present across reset release
    lockIn = 1; txtActive = 1; capActive = 1;
    step(3);
    rstN = 1;
    chk("R1", "irq after reset", {7'd0, irqOut}, 8'h00);
    chk("R1", "req after reset", busRdata, 8'h00);
    phase = "R11";
    step(3);
    chk("R11", "no change at release", busRdata, 8'h00);

    phase = "R3";
    lockIn = 0; step(2);
    chk("R3", "lock fall", busRdata & 8'h08, 8'h08);
    wr(8'h06, 8'h08); step();
    lockIn = 1; step(2);
    chk("R3", "lock rise", busRdata & 8'h08, 8'h08);

    phase = "R4";
    schActive = 1; step();
    xdsActive = 1; step();
    capActive = 0; step();
    txtActive = 0; step(2);
    chk("R4", "all activity bits", busRdata & 8'hF8, 8'hF8);

    phase = "R6";
    wr(8'h06, 8'h00); step();
    chk("R6", "zero write keeps", busRdata & 8'hF8, 8'hF8);
    wr(8'h06, 8'h20); step();
    chk("R6", "single clear", busRdata & 8'hF8, 8'hD8);
    wr(8'h06, 8'hFF); step();
    chk("R6", "all clear", busRdata, 8'h00);

    phase = "R5";
    schActive = 0; step();
    schActive = 1; step(4);
    chk("R5", "pulse sticky", busRdata & 8'h10, 8'h10);
    wr(8'h06, 8'h10);

    phase = "R7";
    eofIn = 1; dleIn = 1; step();
    chk("R7", "status live", busRdata, 8'h06);
    wr(8'h06, 8'hFF); step();
    chk("R7", "status unaffected", busRdata, 8'h06);
    eofIn = 0; step();
    chk("R7", "eof drop", busRdata, 8'h02);
    dleIn = 0; step();

    phase = "R8";
    wr(8'h07, 8'hA5);
    busAddr = 8'h07; step();
    chk("R8", "mask readback", busRdata, 8'hA5);
    phase = "R2";
    busAddr = 8'h05; step();
    chk("R2", "other address", busRdata, 8'h00);
    busAddr = 8'h06;

    phase = "R9";
    wr(8'h07, 8'h01);
    davIn = 1; step();
    chk("R9", "dav irq", {7'd0, irqOut}, 8'h01);
    davIn = 0; eofIn = 1; step();
    chk("R9", "eof masked", {7'd0, irqOut}, 8'h00);
    wr(8'h07, 8'h04); step();
    chk("R9", "eof enabled", {7'd0, irqOut}, 8'h01);
    eofIn = 0; wr(8'h07, 8'h00);

    phase = "R10";
    txtActive = 1; wr(8'h06, 8'h80); step();
    chk("R10", "set beats clear", busRdata & 8'h80, 8'h80);
    wr(8'h06, 8'hF8);

    phase = "R9";
    for (int k = 0; k < 400; k++) begin
      {lockIn, schActive, xdsActive, capActive, txtActive} = 5'($urandom);
      {eofIn, dleIn, davIn} = 3'($urandom);
      if (($urandom % 4) == 0) wr(($urandom % 2) ? 8'h06 : 8'h07, 8'($urandom));
      else step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule